// File: doc/BRIEF.md
# Sparse Coordinate Merge Unit

This unit combines two sparse vectors that arrive as streams of (coordinate, value) pairs, with coordinates strictly ascending and never repeated within a stream. On every accepted step it compares the two current coordinates and consumes the smaller one. When the coordinates are equal it consumes both. In multiply mode it emits only the coordinates that appear in both vectors, each with the product of the two values. In add mode it emits every coordinate that appears in either vector, with the sum of the two values, or with the single value when only one vector has that coordinate. Each input is a valid/ready stream with a last flag. The output is a valid/ready stream of coordinate, value, last, and an empty-result marker.

The control is a state machine with six states:
- `ST_MERGE`: both streams are live and are compared.
- `ST_TAIL_A` and `ST_TAIL_B`: add mode, the other stream has ended. The remaining entries of this stream pass through unchanged.
- `ST_SKIP_A` and `ST_SKIP_B`: multiply mode, the other stream has ended. The remaining entries of this stream are consumed and discarded.
- `ST_FINISH`: releases the final result with last set, or emits an empty marker when nothing was produced.

The transitions are as follows:
- `ST_MERGE` goes to `ST_FINISH` when both lasts are consumed in the same step.
- `ST_MERGE` goes to a tail state (add mode) or a skip state (multiply mode) when only one stream's last is consumed.
- Each tail or skip state goes to `ST_FINISH` when that stream's last is consumed.
- `ST_FINISH` goes back to `ST_MERGE` once the output slot is free.

One computed result is held back in a pending register. This is needed because whether a result is the final one is only known after both streams have ended.

Top module: `sparse_merge_unit`

## Requirements
- R1: After reset, `out_valid`, `a_ready` and `b_ready` are low while no input is valid.
- R2: With `mode_add`=0 (multiply), a coordinate is emitted only when it is present in both inputs. Its value is the low 16 bits of the product of the two signed values.
- R3: With `mode_add`=1 (add), every distinct coordinate of either input is emitted. Its value is the 16-bit truncated sum when both inputs hold it, and the lone value otherwise.
- R4: In `ST_MERGE`, only the input holding the smaller coordinate is consumed. Both inputs are consumed in the same cycle only when their coordinates are equal.
- R5: In multiply mode, once one input delivers its last entry, the remaining entries of the other input are consumed and produce no output.
- R6: In add mode, once one input delivers its last entry, the remaining entries of the other input are emitted with coordinate and value unchanged.
- R7: `out_last` is 1 on the final emitted beat of each result and 0 on every other beat.
- R8: An empty result produces exactly one beat with `out_empty`=1, `out_last`=1 and `out_value`=0.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value, and no result is lost.
- R10: Within one result, the emitted coordinates are strictly ascending.
- R11: The same input vectors give the intersection-product result when `mode_add` is 0 and the union-sum result when it is 1. `mode_add` is held constant for the duration of one pair of vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_add | input | 1 | 1 = union/sum, 0 = intersection/product |
| a_valid | input | 1 | Input A entry valid |
| a_ready | output | 1 | Input A entry accepted |
| a_coord | input | 16 | Input A coordinate, unsigned |
| a_value | input | 16 | Input A value, signed |
| a_last | input | 1 | Final entry of vector A |
| b_valid | input | 1 | Input B entry valid |
| b_ready | output | 1 | Input B entry accepted |
| b_coord | input | 16 | Input B coordinate, unsigned |
| b_value | input | 16 | Input B value, signed |
| b_last | input | 1 | Final entry of vector B |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_coord | output | 16 | Result coordinate |
| out_value | output | 16 | Result value, truncated to 16 bits |
| out_last | output | 1 | Final beat of this result |
| out_empty | output | 1 | Beat marks an empty result |

## Verification
The hardest situation to reach from the ports is the end of a vector pair. At that point the pending result must be released with last set, while one stream is still being drained or skipped and the output is being throttled. The stimulus reaches it with vector pairs whose last entries fall at different positions in the two streams. It also inserts input gaps on a repeating pattern and lowers `out_ready` periodically. One pair is replayed while the output is held stalled for several cycles.

// File: rtl/sparse_merge_pkg.sv
package sparse_merge_pkg;
    typedef enum logic [2:0] {
        ST_MERGE,
        ST_TAIL_A,
        ST_TAIL_B,
        ST_SKIP_A,
        ST_SKIP_B,
        ST_FINISH
    } merge_state_e;
endpackage

// File: rtl/smu_pick.sv
// Compares the two heads, decides which input(s) step, and forms the result.
module smu_pick #(
    parameter int COORD_W = 16,
    parameter int VALUE_W = 16
) (
    input  logic               mode_add,
    input  logic [COORD_W-1:0] a_coord,
    input  logic [VALUE_W-1:0] a_value,
    input  logic [COORD_W-1:0] b_coord,
    input  logic [VALUE_W-1:0] b_value,
    output logic               take_a,
    output logic               take_b,
    output logic               emit,
    output logic [COORD_W-1:0] res_coord,
    output logic [VALUE_W-1:0] res_value
);
    localparam int PROD_W = 2 * VALUE_W;

    logic [PROD_W-1:0]  product;
    logic [VALUE_W-1:0] sum;

    always_comb begin
        take_a    = (a_coord <= b_coord);
        take_b    = (b_coord <= a_coord);
        emit      = mode_add || (take_a && take_b);
        res_coord = take_a ? a_coord : b_coord;
        // Low half of an unsigned product equals low half of the signed one.
        product   = PROD_W'(a_value) * PROD_W'(b_value);
        sum       = a_value + b_value;
        if (take_a && take_b) begin
            res_value = mode_add ? sum : product[VALUE_W-1:0];
        end else begin
            res_value = take_a ? a_value : b_value;
        end
    end
endmodule

// File: rtl/smu_result_hold.sv
// One pending result plus the output register; the pending entry only
// becomes visible once its successor (or the end of the vector) is known.
module smu_result_hold #(
    parameter int COORD_W = 16,
    parameter int VALUE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [COORD_W-1:0] push_coord,
    input  logic [VALUE_W-1:0] push_value,
    input  logic               close,
    input  logic               out_ready,
    output logic               can_push,
    output logic               can_close,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_coord,
    output logic [VALUE_W-1:0] out_value,
    output logic               out_last,
    output logic               out_empty
);
    logic               pend_valid;
    logic [COORD_W-1:0] pend_coord;
    logic [VALUE_W-1:0] pend_value;
    logic               out_free;

    always_comb begin
        out_free  = !out_valid || out_ready;
        can_push  = !pend_valid || out_free;
        can_close = out_free;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_coord <= '0;
            pend_value <= '0;
            out_valid  <= 1'b0;
            out_coord  <= '0;
            out_value  <= '0;
            out_last   <= 1'b0;
            out_empty  <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (push) begin
                if (pend_valid) begin
                    out_valid <= 1'b1;
                    out_coord <= pend_coord;
                    out_value <= pend_value;
                    out_last  <= 1'b0;
                    out_empty <= 1'b0;
                end
                pend_valid <= 1'b1;
                pend_coord <= push_coord;
                pend_value <= push_value;
            end else if (close) begin
                out_valid  <= 1'b1;
                out_coord  <= pend_valid ? pend_coord : '0;
                out_value  <= pend_valid ? pend_value : '0;
                out_last   <= 1'b1;
                out_empty  <= !pend_valid;
                pend_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sparse_merge_unit.sv
module sparse_merge_unit
    import sparse_merge_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int VALUE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_add,
    input  logic               a_valid,
    output logic               a_ready,
    input  logic [COORD_W-1:0] a_coord,
    input  logic [VALUE_W-1:0] a_value,
    input  logic               a_last,
    input  logic               b_valid,
    output logic               b_ready,
    input  logic [COORD_W-1:0] b_coord,
    input  logic [VALUE_W-1:0] b_value,
    input  logic               b_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [COORD_W-1:0] out_coord,
    output logic [VALUE_W-1:0] out_value,
    output logic               out_last,
    output logic               out_empty
);
    merge_state_e state_q, state_d;

    logic               take_a, take_b, emit;
    logic [COORD_W-1:0] pick_coord;
    logic [VALUE_W-1:0] pick_value;
    logic               push, close, can_push, can_close;
    logic [COORD_W-1:0] push_coord;
    logic [VALUE_W-1:0] push_value;
    logic               a_done, b_done;

    smu_pick #(.COORD_W(COORD_W), .VALUE_W(VALUE_W)) u_pick (
        .mode_add (mode_add),
        .a_coord  (a_coord),
        .a_value  (a_value),
        .b_coord  (b_coord),
        .b_value  (b_value),
        .take_a   (take_a),
        .take_b   (take_b),
        .emit     (emit),
        .res_coord(pick_coord),
        .res_value(pick_value)
    );

    smu_result_hold #(.COORD_W(COORD_W), .VALUE_W(VALUE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_coord(push_coord),
        .push_value(push_value),
        .close     (close),
        .out_ready (out_ready),
        .can_push  (can_push),
        .can_close (can_close),
        .out_valid (out_valid),
        .out_coord (out_coord),
        .out_value (out_value),
        .out_last  (out_last),
        .out_empty (out_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MERGE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        a_ready    = 1'b0;
        b_ready    = 1'b0;
        push       = 1'b0;
        close      = 1'b0;
        push_coord = pick_coord;
        push_value = pick_value;
        a_done     = 1'b0;
        b_done     = 1'b0;
        unique case (state_q)
            ST_MERGE: begin
                if (a_valid && b_valid && (!emit || can_push)) begin
                    a_ready = take_a;
                    b_ready = take_b;
                    push    = emit;
                    a_done  = take_a && a_last;
                    b_done  = take_b && b_last;
                    if (a_done && b_done) begin
                        state_d = ST_FINISH;
                    end else if (a_done) begin
                        state_d = mode_add ? ST_TAIL_B : ST_SKIP_B;
                    end else if (b_done) begin
                        state_d = mode_add ? ST_TAIL_A : ST_SKIP_A;
                    end
                end
            end
            ST_TAIL_A: begin
                if (a_valid && can_push) begin
                    a_ready    = 1'b1;
                    push       = 1'b1;
                    push_coord = a_coord;
                    push_value = a_value;
                    if (a_last) state_d = ST_FINISH;
                end
            end
            ST_TAIL_B: begin
                if (b_valid && can_push) begin
                    b_ready    = 1'b1;
                    push       = 1'b1;
                    push_coord = b_coord;
                    push_value = b_value;
                    if (b_last) state_d = ST_FINISH;
                end
            end
            ST_SKIP_A: begin
                if (a_valid) begin
                    a_ready = 1'b1;
                    if (a_last) state_d = ST_FINISH;
                end
            end
            ST_SKIP_B: begin
                if (b_valid) begin
                    b_ready = 1'b1;
                    if (b_last) state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (can_close) begin
                    close   = 1'b1;
                    state_d = ST_MERGE;
                end
            end
            default: state_d = ST_MERGE;
        endcase
    end
endmodule

// File: rtl/sparse_merge_unit_checker.sv
module sparse_merge_unit_checker #(
    parameter int COORD_W = 16,
    parameter int VALUE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               a_valid,
    input logic               a_ready,
    input logic [COORD_W-1:0] a_coord,
    input logic               b_valid,
    input logic               b_ready,
    input logic [COORD_W-1:0] b_coord,
    input logic               out_valid,
    input logic               out_ready,
    input logic [COORD_W-1:0] out_coord,
    input logic [VALUE_W-1:0] out_value,
    input logic               out_last,
    input logic               out_empty
);
    logic               seen_beat;
    logic [COORD_W-1:0] prev_coord;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_beat  <= 1'b0;
            prev_coord <= '0;
        end else if (out_valid && out_ready) begin
            seen_beat  <= !out_last;
            prev_coord <= out_coord;
        end
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_coord) &&
        $stable(out_value) && $stable(out_last) && $stable(out_empty));

    assert_empty_is_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_last && (out_value == '0));

    assert_joint_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && a_ready && b_valid && b_ready |-> a_coord == b_coord);

    assert_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && seen_beat |-> out_coord > prev_coord);
endmodule

bind sparse_merge_unit sparse_merge_unit_checker #(
    .COORD_W(COORD_W),
    .VALUE_W(VALUE_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .a_coord  (a_coord),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .b_coord  (b_coord),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_coord(out_coord),
    .out_value(out_value),
    .out_last (out_last),
    .out_empty(out_empty)
);

// File: tb/sparse_merge_unit_test.sv
module sparse_merge_unit_test;
    localparam int P = 10;
    localparam int NCASE = 9;

    typedef struct packed {
        logic              mode;
        logic [2:0]        na;
        logic [2:0]        nb;
        logic [0:3][15:0]  ac;
        logic [0:3][15:0]  av;
        logic [0:3][15:0]  bc;
        logic [0:3][15:0]  bv;
        logic [3:0]        ne;
        logic [0:5][15:0]  ec;
        logic [0:5][15:0]  ev;
    } case_t;

    localparam case_t CASES [NCASE] = '{
        '{1'b0, 3'd3, 3'd3, '{16'd1, 16'd3, 16'd7, 16'd0}, '{16'd2, 16'd5, 16'hFFFF, 16'd0},
          '{16'd3, 16'd7, 16'd9, 16'd0}, '{16'd4, 16'd6, 16'd9, 16'd0},
          4'd2, '{16'd3, 16'd7, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd20, 16'hFFFA, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b1, 3'd2, 3'd4, '{16'd2, 16'd5, 16'd0, 16'd0}, '{16'd10, 16'd1, 16'd0, 16'd0},
          '{16'd1, 16'd5, 16'd8, 16'd9}, '{16'd3, 16'hFFFC, 16'd7, 16'd2},
          4'd5, '{16'd1, 16'd2, 16'd5, 16'd8, 16'd9, 16'd0}, '{16'd3, 16'd10, 16'hFFFD, 16'd7, 16'd2, 16'd0}},
        '{1'b0, 3'd2, 3'd2, '{16'd1, 16'd4, 16'd0, 16'd0}, '{16'd1, 16'd1, 16'd0, 16'd0},
          '{16'd2, 16'd6, 16'd0, 16'd0}, '{16'd1, 16'd1, 16'd0, 16'd0},
          4'd0, '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b1, 3'd3, 3'd1, '{16'd0, 16'd6, 16'd10, 16'd0}, '{16'd1, 16'd2, 16'd3, 16'd0},
          '{16'd6, 16'd0, 16'd0, 16'd0}, '{16'd5, 16'd0, 16'd0, 16'd0},
          4'd3, '{16'd0, 16'd6, 16'd10, 16'd0, 16'd0, 16'd0}, '{16'd1, 16'd7, 16'd3, 16'd0, 16'd0, 16'd0}},
        '{1'b0, 3'd1, 3'd1, '{16'd100, 16'd0, 16'd0, 16'd0}, '{16'd300, 16'd0, 16'd0, 16'd0},
          '{16'd100, 16'd0, 16'd0, 16'd0}, '{16'd300, 16'd0, 16'd0, 16'd0},
          4'd1, '{16'd100, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd24464, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b1, 3'd1, 3'd1, '{16'd4, 16'd0, 16'd0, 16'd0}, '{16'd32767, 16'd0, 16'd0, 16'd0},
          '{16'd4, 16'd0, 16'd0, 16'd0}, '{16'd1, 16'd0, 16'd0, 16'd0},
          4'd1, '{16'd4, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'h8000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b0, 3'd1, 3'd4, '{16'd2, 16'd0, 16'd0, 16'd0}, '{16'd3, 16'd0, 16'd0, 16'd0},
          '{16'd1, 16'd2, 16'd5, 16'd6}, '{16'd1, 16'd4, 16'd5, 16'd6},
          4'd1, '{16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd12, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b1, 3'd1, 3'd1, '{16'hFFFF, 16'd0, 16'd0, 16'd0}, '{16'hFFFE, 16'd0, 16'd0, 16'd0},
          '{16'hFFFF, 16'd0, 16'd0, 16'd0}, '{16'hFFFD, 16'd0, 16'd0, 16'd0},
          4'd1, '{16'hFFFF, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'hFFFB, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
        '{1'b0, 3'd1, 3'd1, '{16'hFFFF, 16'd0, 16'd0, 16'd0}, '{16'hFFFE, 16'd0, 16'd0, 16'd0},
          '{16'hFFFF, 16'd0, 16'd0, 16'd0}, '{16'hFFFD, 16'd0, 16'd0, 16'd0},
          4'd1, '{16'hFFFF, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd6, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}}
    };

    localparam case_t DIR_CASE = '{1'b1, 3'd1, 3'd1,
        '{16'd3, 16'd0, 16'd0, 16'd0}, '{16'd1, 16'd0, 16'd0, 16'd0},
        '{16'd8, 16'd0, 16'd0, 16'd0}, '{16'd2, 16'd0, 16'd0, 16'd0},
        4'd2, '{16'd3, 16'd8, 16'd0, 16'd0, 16'd0, 16'd0}, '{16'd1, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_add = 1'b0;
    logic        a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0;
    logic [15:0] a_coord = '0, a_value = '0, b_coord = '0, b_value = '0;
    logic        out_ready = 1'b0;
    logic        a_ready, b_ready, out_valid, out_last, out_empty;
    logic [15:0] out_coord, out_value;

    int checks = 0;
    int failures = 0;

    always #(P/2) clk = ~clk;

    sparse_merge_unit uut (
        .clk(clk), .rst_n(rst_n), .mode_add(mode_add),
        .a_valid(a_valid), .a_ready(a_ready), .a_coord(a_coord), .a_value(a_value), .a_last(a_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_coord(b_coord), .b_value(b_value), .b_last(b_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_coord(out_coord),
        .out_value(out_value), .out_last(out_last), .out_empty(out_empty)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string case_tag(input int i);
        case (i)
            0, 6:    return "R5";
            1, 3:    return "R6";
            2:       return "R8";
            4:       return "R2";
            5:       return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic drive_a(input case_t c, input int seed);
        for (int k = 0; k < int'(c.na); k++) begin
            bit got;
            if (k > 0 && ((k + seed) % 3) == 1) begin
                a_valid = 1'b0;
                @(negedge clk);
            end
            a_valid = 1'b1; a_coord = c.ac[k]; a_value = c.av[k]; a_last = (k == int'(c.na) - 1);
            do begin
                #(P/4);
                got = a_ready;
                @(negedge clk);
            end while (!got);
        end
        a_valid = 1'b0; a_last = 1'b0;
    endtask

    task automatic drive_b(input case_t c, input int seed);
        for (int k = 0; k < int'(c.nb); k++) begin
            bit got;
            if (k > 0 && ((k + seed) % 3) == 1) begin
                b_valid = 1'b0;
                @(negedge clk);
            end
            b_valid = 1'b1; b_coord = c.bc[k]; b_value = c.bv[k]; b_last = (k == int'(c.nb) - 1);
            do begin
                #(P/4);
                got = b_ready;
                @(negedge clk);
            end while (!got);
        end
        b_valid = 1'b0; b_last = 1'b0;
    endtask

    task automatic collect(input case_t c, input string tag, input bit stall);
        int got = 0;
        int n = 0;
        bit done = 0;
        bit have = 0;
        logic [15:0] prev = '0;
        string vtag = c.mode ? "R3" : "R2";
        if (stall) begin
            logic [15:0] hc, hv;
            logic hl;
            bit steady = 1;
            out_ready = 1'b0;
            #(P/4);
            while (!out_valid) begin
                @(negedge clk);
                #(P/4);
            end
            hc = out_coord; hv = out_value; hl = out_last;
            repeat (5) begin
                @(negedge clk);
                #(P/4);
                if (!out_valid || out_coord != hc || out_value != hv || out_last != hl) steady = 0;
            end
            check(steady, "R9", "output held under stall", int'(out_coord), int'(hc));
            @(negedge clk);
        end
        while (!done) begin
            out_ready = ((n % 4) != 3);
            n++;
            #(P/4);
            if (out_valid && out_ready) begin
                if (c.ne == 0) begin
                    check(out_empty && out_last && out_value == 0, "R8", "empty marker beat",
                          int'({out_empty, out_last}), 3);
                end else if (got >= int'(c.ne)) begin
                    check(0, "R7", "extra beat after last", got, int'(c.ne));
                end else begin
                    check(out_coord == c.ec[got], vtag, "coordinate", int'(out_coord), int'(c.ec[got]));
                    check(out_value == c.ev[got], vtag, "value", int'(out_value), int'(c.ev[got]));
                    check(out_last == (got == int'(c.ne) - 1), "R7", "last flag",
                          int'(out_last), int'(got == int'(c.ne) - 1));
                    if (have) check(out_coord > prev, "R10", "ascending", int'(out_coord), int'(prev) + 1);
                end
                prev = out_coord;
                have = 1;
                got++;
                if (out_last) done = 1;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(got == ((c.ne == 0) ? 1 : int'(c.ne)), tag, "beat count", got,
              (c.ne == 0) ? 1 : int'(c.ne));
    endtask

    task automatic run_case(input case_t c, input string tag, input int seed, input bit stall);
        mode_add = c.mode;
        fork
            drive_a(c, seed);
            drive_b(c, seed + 1);
            collect(c, tag, stall);
        join
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(P/4);
        // R1: quiet after reset with no input valid
        check(!out_valid && !a_ready && !b_ready, "R1", "reset state",
              int'({out_valid, a_ready, b_ready}), 0);
        @(negedge clk);

        for (int i = 0; i < NCASE; i++) begin
            run_case(CASES[i], case_tag(i), i, 1'b0);
        end

        // R9: replay the add-mode tail case with the output stalled
        run_case(CASES[1], "R9", 5, 1'b1);

        // R4 and R6 directed: smaller coordinate steps alone, then tail passes
        mode_add = 1'b1;
        fork
            begin
                a_valid = 1'b1; a_coord = 16'd3; a_value = 16'd1; a_last = 1'b1;
                b_valid = 1'b1; b_coord = 16'd8; b_value = 16'd2; b_last = 1'b1;
                #(P/4);
                check(a_ready && !b_ready, "R4", "only smaller head consumed",
                      int'({a_ready, b_ready}), 2);
                @(negedge clk);
                a_valid = 1'b0; a_last = 1'b0;
                #(P/4);
                check(b_ready, "R6", "tail entry accepted", int'(b_ready), 1);
                @(negedge clk);
                b_valid = 1'b0; b_last = 1'b0;
            end
            collect(DIR_CASE, "R4", 1'b0);
        join
        @(negedge clk);

        summary();
        $finish;
    end
endmodule